// File: doc/BRIEF.md
# Address-Dependent CPU Clock Rate Selector

This block turns a master clock into the quadrature pair of CPU bus clocks, E and Q. Each bus cycle lasts either 8 or 16 master clocks. The length is chosen from a 2-bit rate field, a map-type bit and the address of the access. In the slow setting every cycle takes 16 master clocks. In the fast settings every cycle takes 8.

In the address-dependent setting, accesses that decode as ROM get the short cycle and accesses to RAM get the long one, so the cycle length can change from one access to the next. When the map-type bit selects the all-RAM map, the block forces the long cycle whatever the rate field says.

The ratio is latched at the edge that ends a cycle, which is the edge where E falls. A cycle that is already under way is never cut short or stretched. A status output reports which ratio the current cycle uses.

Top module: `cpu_rate_gen`

## Requirements
- R1: While reset is low, e_o, q_o and fast_o are all 0. The first cycle after reset is a 16-clock cycle.
- R2: With rate_i = 2'b00 and map_ram_i = 0, every cycle lasts 16 master clocks.
- R3: With rate_i = 2'b10 and map_ram_i = 0, every cycle lasts 8 master clocks.
- R4: With rate_i = 2'b11 and map_ram_i = 0, every cycle lasts 8 master clocks.
- R5: With rate_i = 2'b01 and map_ram_i = 0, a cycle lasts 8 clocks if its address is in 16'h8000..16'hFEFF. Every other address gives a 16-clock cycle.
- R6: With map_ram_i = 1, every cycle lasts 16 clocks for any rate_i and address.
- R7: rate_i, map_ram_i and addr_i are sampled only at the master clock edge where E falls. That sample sets the length of the cycle that starts at this edge. Changes at any other time have no effect on the cycle in progress.
- R8: E is low for the first half of each cycle and high for the second half (50% duty cycle).
- R9: Q rises a quarter of the cycle before E rises. Q falls a quarter of the cycle before E falls, so its duty cycle is also 50%.
- R10: fast_o is 1 for the whole of an 8-clock cycle and 0 for the whole of a 16-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 2 | Rate field: bit 1 is R1, bit 0 is R0 |
| map_ram_i | input | 1 | Map type: 1 selects the all-RAM map and forces the slow rate |
| addr_i | input | 16 | CPU address of the next access |
| e_o | output | 1 | E bus clock |
| q_o | output | 1 | Q bus clock, leads E by a quarter cycle |
| fast_o | output | 1 | 1 while the current cycle uses the 8-clock ratio |

## Verification
Inputs present at the edge where E falls set the cycle that starts at that edge. For that cycle of N clocks:
- Q rises N/4 clocks later.
- E rises N/2 clocks later.
- Q falls 3N/4 clocks later.
- E falls again N clocks later.

The driver changes the inputs only on the falling master clock edge after each E fall. Each new value therefore applies to the next cycle but one, and the driver queues the length it expects for that cycle.

The monitor timestamps every E and Q edge and converts the gaps into master clock counts. At the E fall that closes a cycle, it checks the period, the high times and the quarter-cycle offsets against the head of the queue. It samples fast_o at the rising edge of E, in the middle of the cycle.

// File: rtl/cpu_rate_pkg.sv
package cpu_rate_pkg;
  typedef enum logic [1:0] {
    RATE_SLOW    = 2'b00,
    RATE_ADDR    = 2'b01,
    RATE_FAST    = 2'b10,
    RATE_FAST_NR = 2'b11
  } rate_e;
endpackage

// File: rtl/cpu_rate_decode.sv
module cpu_rate_decode
  import cpu_rate_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned ROM_LO = 'h8000,
  parameter int unsigned ROM_HI = 'hFEFF
) (
  input  logic [1:0]    rate_i,
  input  logic          map_ram_i,
  input  logic [AW-1:0] addr_i,
  output logic          fast_o
);
  localparam logic [AW-1:0] LO = AW'(ROM_LO);
  localparam logic [AW-1:0] HI = AW'(ROM_HI);

  logic in_rom;
  assign in_rom = (addr_i >= LO) && (addr_i <= HI);

  always_comb begin
    unique case (rate_e'(rate_i))
      RATE_SLOW: fast_o = 1'b0;
      RATE_ADDR: fast_o = in_rom;
      default:   fast_o = 1'b1;
    endcase
    // all-RAM map only allows the slow rate
    if (map_ram_i) fast_o = 1'b0;
  end
endmodule

// File: rtl/cpu_phase_gen.sv
module cpu_phase_gen #(
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_req_i,
  output logic e_o,
  output logic q_o,
  output logic fast_o,
  output logic cyc_end_o
);
  localparam int unsigned CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] F_LAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] S_LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] F_QTR  = CW'(FAST_DIV / 4);
  localparam logic [CW-1:0] S_QTR  = CW'(SLOW_DIV / 4);
  localparam logic [CW-1:0] F_HALF = CW'(FAST_DIV / 2);
  localparam logic [CW-1:0] S_HALF = CW'(SLOW_DIV / 2);
  localparam logic [CW-1:0] F_3QTR = CW'(3 * FAST_DIV / 4);
  localparam logic [CW-1:0] S_3QTR = CW'(3 * SLOW_DIV / 4);

  logic [CW-1:0] cnt_q;
  logic          fast_q;
  logic [CW-1:0] last, qtr, half, qtr3;

  assign last = fast_q ? F_LAST : S_LAST;
  assign qtr  = fast_q ? F_QTR  : S_QTR;
  assign half = fast_q ? F_HALF : S_HALF;
  assign qtr3 = fast_q ? F_3QTR : S_3QTR;

  assign cyc_end_o = (cnt_q == last);

  // ratio latched only at the cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else if (cyc_end_o) begin
      cnt_q  <= '0;
      fast_q <= fast_req_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign e_o    = (cnt_q >= half);
  assign q_o    = (cnt_q >= qtr) && (cnt_q < qtr3);
  assign fast_o = fast_q;

  a_r7_ratio_held_mid_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end_o |=> $stable(fast_q));
  a_r9_q_high_at_e_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(e_o) |-> q_o);
  a_r9_q_low_at_e_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_o) |-> !q_o);
  a_r8_e_falls_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_o) |-> (cnt_q == '0));
endmodule

// File: rtl/cpu_rate_gen.sv
module cpu_rate_gen #(
  parameter int unsigned AW       = 16,
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned SLOW_DIV = 16,
  parameter int unsigned ROM_LO   = 'h8000,
  parameter int unsigned ROM_HI   = 'hFEFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    rate_i,
  input  logic          map_ram_i,
  input  logic [AW-1:0] addr_i,
  output logic          e_o,
  output logic          q_o,
  output logic          fast_o
);
  logic fast_req;
  logic cyc_end;

  cpu_rate_decode #(.AW(AW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_decode (
    .rate_i    (rate_i),
    .map_ram_i (map_ram_i),
    .addr_i    (addr_i),
    .fast_o    (fast_req)
  );

  cpu_phase_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_req_i (fast_req),
    .e_o        (e_o),
    .q_o        (q_o),
    .fast_o     (fast_o),
    .cyc_end_o  (cyc_end)
  );

  a_r6_map_forces_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end && map_ram_i) |=> !fast_o);
  a_r2_slow_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end && rate_i == 2'b00) |=> !fast_o);
  a_r3_fast_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end && !map_ram_i && rate_i[1]) |=> fast_o);
endmodule

// File: tb/test_cpu_rate_gen.sv
module test_cpu_rate_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [1:0]  rate_i = 2'b00;
  logic        map_ram_i = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic        e_o, q_o, fast_o;

  always #2.5 clk_i = ~clk_i;

  cpu_rate_gen i_cpu_rate_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(rate_i), .map_ram_i(map_ram_i),
    .addr_i(addr_i), .e_o(e_o), .q_o(q_o), .fast_o(fast_o)
  );

  typedef struct { int div; string tag; } exp_t;
  typedef struct { logic [1:0] r; logic m; logic [15:0] a; string tag; } stim_t;

  exp_t  q_exp[$];
  stim_t stims[$];
  int    checks = 0;
  int    errors = 0;
  int    mon_n  = 0;
  bit    go     = 0;
  bit    done   = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_div(logic [1:0] r, logic m, logic [15:0] a);
    if (m) return 16;
    case (r)
      2'b00:   return 16;
      2'b01:   return (a >= 16'h8000 && a <= 16'hFEFF) ? 8 : 16;
      default: return 8;
    endcase
  endfunction

  function automatic int clks(realtime d);
    return int'(d / 5.0);
  endfunction

  task automatic add(logic [1:0] r, logic m, logic [15:0] a, string tag);
    stim_t s;
    s.r = r; s.m = m; s.a = a; s.tag = tag;
    stims.push_back(s);
  endtask

  task automatic drive(stim_t s);
    exp_t x;
    rate_i = s.r; map_ram_i = s.m; addr_i = s.a;
    x.div = ref_div(s.r, s.m, s.a);
    x.tag = s.tag;
    q_exp.push_back(x);
  endtask

  // monitor: timestamps edges, compares against queue head
  initial begin
    realtime t_qr, t_er, t_qf, t_ef, t_now;
    bit have_ef;
    exp_t cur;
    have_ef = 0;
    t_qr = 0; t_er = 0; t_qf = 0; t_ef = 0;
    wait (go);
    forever begin
      @(posedge q_o); t_qr = $realtime;
      @(posedge e_o); t_er = $realtime;
      if (q_exp.size() == 0) begin
        errors++; checks++;
        $display("FAIL R7 actual=0 expected=1 (no expected cycle queued)");
        cur.div = 0; cur.tag = "R7";
      end else cur = q_exp[0];
      chk(clks(t_er - t_qr) == cur.div / 4, {cur.tag, "/R9 q lead"}, clks(t_er - t_qr), cur.div / 4);
      chk(fast_o == (cur.div == 8), {cur.tag, "/R10 fast_o"}, fast_o, cur.div == 8);
      @(negedge q_o); t_qf = $realtime;
      chk(clks(t_qf - t_er) == cur.div / 4, {cur.tag, "/R9 q fall"}, clks(t_qf - t_er), cur.div / 4);
      @(negedge e_o); t_now = $realtime;
      chk(clks(t_now - t_er) == cur.div / 2, {cur.tag, "/R8 e high"}, clks(t_now - t_er), cur.div / 2);
      chk(clks(t_now - t_qf) == cur.div / 4, {cur.tag, "/R9 q to e fall"}, clks(t_now - t_qf), cur.div / 4);
      if (have_ef)
        chk(clks(t_now - t_ef) == cur.div, {cur.tag, "/R7 period"}, clks(t_now - t_ef), cur.div);
      t_ef = t_now;
      have_ef = 1;
      if (q_exp.size() != 0) void'(q_exp.pop_front());
      mon_n++;
    end
  end

  // driver
  initial begin
    exp_t x0;
    add(2'b00, 1'b0, 16'h8000, "R2");
    add(2'b00, 1'b0, 16'h1234, "R2");
    add(2'b10, 1'b0, 16'h1234, "R3");
    add(2'b10, 1'b0, 16'hC000, "R3");
    add(2'b11, 1'b0, 16'h0000, "R4");
    add(2'b11, 1'b0, 16'hFFFF, "R4");
    add(2'b01, 1'b0, 16'h8000, "R5");
    add(2'b01, 1'b0, 16'h7FFF, "R5");
    add(2'b01, 1'b0, 16'hFEFF, "R5");
    add(2'b01, 1'b0, 16'hFF00, "R5");
    add(2'b01, 1'b0, 16'hA000, "R5");
    add(2'b01, 1'b0, 16'hFFFF, "R5");
    add(2'b01, 1'b0, 16'hC123, "R5");
    add(2'b01, 1'b0, 16'h0000, "R5");
    add(2'b10, 1'b1, 16'h4000, "R6");
    add(2'b11, 1'b1, 16'hC000, "R6");
    add(2'b01, 1'b1, 16'h9000, "R6");
    add(2'b00, 1'b0, 16'h0000, "R2");
    add(2'b10, 1'b0, 16'h0000, "R7");

    #1 rst_ni = 1'b0;
    #10;
    chk(e_o == 1'b0, "R1 e in reset", e_o, 0);
    chk(q_o == 1'b0, "R1 q in reset", q_o, 0);
    chk(fast_o == 1'b0, "R1 fast in reset", fast_o, 0);
    x0.div = 16; x0.tag = "R1";
    q_exp.push_back(x0);
    drive(stims[0]);
    go = 1;
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 1; i < stims.size(); i++) begin
      @(negedge e_o);
      @(negedge clk_i);
      drive(stims[i]);
    end
    wait (mon_n == stims.size() + 1);
    @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d cycles", mon_n, stims.size() + 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule